// File: doc/BRIEF.md
# MFM Read Data Separator

This block turns a serial stream of flux pulses from one of several drives into recovered bytes. The system clock runs at four times the bit-cell rate, and each system clock is one oversample tick. A two-bit select picks one drive line. That line passes through a two-stage synchronizer and a rising-edge detector. While the read gate is open, the detected edges steer a digital phase tracker. While the gate is closed, the tracker is steered by pulses from a local reference divider instead, so it stays close to the cell rate between reads. The same divider also drives a double-rate reference output and a cell-rate write clock output.

The tracker divides each bit cell into a clock half-window and a data half-window. Each pulse moves the cell boundary by at most one tick toward the pulse. A pulse in the data half of a cell makes that cell's bit a one. A pulse in the clock half adds nothing to the data. Decoded bits are shifted in most significant bit first. Every eighth bit produces a byte and a single-cycle valid strobe.

Top module: `mfm_read_sep`

## Requirements
- R1: During synchronous reset, byte_o is 0 and byte_vld_o, rclk_o, ref2x_o and wclk_o are all 0.
- R2: After reset is released, a free-running tick counter drives the clock outputs. wclk_o has a period of OSR ticks and ref2x_o has a period of OSR/2 ticks, each with 50% duty. Both are low in the first tick after reset, ref2x_o is high in odd ticks, and wclk_o is high in the second half of every OSR-tick period.
- R3: Only the drive line indexed by drv_sel_i affects the decoded bytes. Toggling activity on the other lines changes nothing.
- R4: While read_gate_i is low, the tracker locks to the reference divider and ignores pulses on the selected drive line. rclk_o keeps a steady OSR-tick period whatever that line does.
- R5: A bit cell is OSR ticks long, numbered 0 to OSR-1. Ticks below OSR/2 form the clock window and the rest form the data window. rclk_o is high exactly in the data window. A drive pulse raised during the tick before clock edge k is judged at the tick phase that holds between edges k+1 and k+2. With no correction, the phase advances by one tick per clock.
- R6: A cell that saw a pulse in its data window decodes as 1. A cell with no data-window pulse decodes as 0, even if it saw a clock-window pulse. A stream in which a clock pulse appears only between two zero bits therefore decodes back to the bytes that produced it.
- R7: The window centres are tick OSR/4 and tick 3*OSR/4. A pulse judged before its window centre moves the phase forward two ticks instead of one. A pulse judged after the centre holds the phase for one tick. A pulse judged at the centre changes nothing.
- R8: Bytes are framed from the first whole cell that starts after read_gate_i rises, and bits enter most significant first. byte_vld_o is high for exactly one clock, in the tick after the eighth cell ends, which is tick 0 of the next cell. byte_o holds the byte.
- R9: When read_gate_i goes low, a partly assembled byte is discarded. The next byte after the gate reopens is framed afresh.
- R10: A data pulse judged in the last tick of a cell counts toward that cell's bit, including when that cell ends a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversample clock, OSR ticks per bit cell |
| rst | input | 1 | Synchronous reset, active high |
| drv_i | input | NDRV | Flux pulse lines, one per drive, active high |
| drv_sel_i | input | SELW | Index of the drive line to decode |
| read_gate_i | input | 1 | High to decode drive data, low to track the reference |
| byte_o | output | BW | Last assembled byte |
| byte_vld_o | output | 1 | One-clock strobe for a new byte |
| rclk_o | output | 1 | Recovered cell clock, high during the data window |
| ref2x_o | output | 1 | Reference square wave at twice the cell rate |
| wclk_o | output | 1 | Write clock square wave at the cell rate |

## Verification
The collision that matters is a data pulse judged in the final tick of a cell, which is also the tick in which the cell ends and, every eighth cell, a byte completes. With the default four ticks per cell, the data-window centre is that last tick, so the bench times every one bit to land there. All-ones bytes and bytes ending in a one exercise the case on every byte boundary. The result is judged by comparing each strobed byte with the byte the bench encoded, and by checking that the strobe arrives in tick 0 of the following cell.

// File: rtl/mfm_sep_pkg.sv
package mfm_sep_pkg;

  // Signed distance of a tick phase from the centre of the half-window it falls in.
  function automatic int phase_err(input int osr, input int ph);
    int ctr;
    ctr = (ph >= osr / 2) ? (3 * osr) / 4 : osr / 4;
    return ph - ctr;
  endfunction

  // Phase step for one tick: 2 pulls an early pulse in, 0 lets a late pulse catch up.
  function automatic logic [1:0] step_for(input int err);
    if (err < 0) return 2'd2;
    if (err > 0) return 2'd0;
    return 2'd1;
  endfunction

endpackage

// File: rtl/mfm_ref_div.sv
module mfm_ref_div #(
  parameter int OSR = 4,
  localparam int PW = $clog2(OSR)
) (
  input  logic clk,
  input  logic rst,
  output logic ref_pulse_o,
  output logic ref2x_o,
  output logic wclk_o
);

  logic [PW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) dcnt <= '0;
    else     dcnt <= dcnt + PW'(1);
  end

  always_comb begin
    wclk_o      = dcnt[PW-1];
    ref2x_o     = dcnt[PW-2];
    ref_pulse_o = (dcnt[PW-2:0] == '0);
  end

  AST_WCLK_REF_PHASE: assert property (@(posedge clk) disable iff (rst)
    $rose(wclk_o) |-> ($past(ref2x_o) && !ref2x_o)); // R2

endmodule

// File: rtl/mfm_in_select.sv
module mfm_in_select #(
  parameter int NDRV   = 4,
  parameter int SELW   = 2,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDRV-1:0] drv_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            read_gate_i,
  input  logic            ref_pulse_i,
  output logic            trk_pulse_o
);

  logic            raw;
  logic [SYNC_N:0] sh;
  logic            data_edge;

  assign raw = drv_i[sel_i];

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_N-1:0], raw};
  end

  always_comb begin
    data_edge   = sh[SYNC_N-1] & ~sh[SYNC_N];
    trk_pulse_o = read_gate_i ? data_edge : ref_pulse_i;
  end

endmodule

// File: rtl/mfm_phase_track.sv
module mfm_phase_track #(
  parameter int OSR = 4,
  localparam int PW = $clog2(OSR)
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic cell_end_o,
  output logic dbit_o,
  output logic rclk_o
);

  localparam logic [PW:0] OSR_V = (PW+1)'(OSR);

  logic [PW-1:0] ph;
  logic          in_data;
  int            err;
  logic          early;
  logic          late;
  logic [1:0]    step;
  logic [PW:0]   sum;
  logic          data_seen;

  always_comb begin
    in_data    = ph[PW-1];
    err        = mfm_sep_pkg::phase_err(OSR, int'(ph));
    early      = pulse_i && (err < 0);
    late       = pulse_i && (err > 0);
    step       = pulse_i ? mfm_sep_pkg::step_for(err) : 2'd1;
    sum        = {1'b0, ph} + {{(PW-1){1'b0}}, step};
    cell_end_o = (sum >= OSR_V);
    dbit_o     = data_seen | (pulse_i & in_data);
    rclk_o     = ph[PW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      data_seen <= 1'b0;
    end else begin
      ph <= cell_end_o ? PW'(sum - OSR_V) : sum[PW-1:0];
      if (cell_end_o)              data_seen <= 1'b0;
      else if (pulse_i && in_data) data_seen <= 1'b1;
    end
  end

  AST_PHASE_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    !pulse_i |=> (ph == $past(ph) + PW'(1))); // R5
  AST_EARLY_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    early |=> (ph == $past(ph) + PW'(2))); // R7
  AST_LATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    late |=> (ph == $past(ph))); // R7

endmodule

// File: rtl/mfm_byte_asm.sv
module mfm_byte_asm #(
  parameter int BW = 8,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          read_gate_i,
  input  logic          cell_end_i,
  input  logic          dbit_i,
  output logic [BW-1:0] byte_o,
  output logic          byte_vld_o
);

  logic          armed;
  logic [CW-1:0] bitcnt;
  logic [BW-1:0] sr;
  logic [BW-1:0] sr_nxt;
  logic          take;
  logic          last;

  always_comb begin
    take   = cell_end_i & armed & read_gate_i;
    sr_nxt = {sr[BW-2:0], dbit_i};
    last   = (bitcnt == CW'(BW-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      bitcnt     <= '0;
      sr         <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!read_gate_i) begin
        armed  <= 1'b0;
        bitcnt <= '0;
        sr     <= '0;
      end else begin
        if (cell_end_i) armed <= 1'b1;
        if (take) begin
          sr <= sr_nxt;
          if (last) begin
            byte_o     <= sr_nxt;
            byte_vld_o <= 1'b1;
            bitcnt     <= '0;
          end else begin
            bitcnt <= bitcnt + CW'(1);
          end
        end
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |=> !byte_vld_o); // R8
  AST_STROBE_AT_CELL_END: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> $past(cell_end_i && read_gate_i)); // R8
  AST_GATE_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !read_gate_i |=> ((bitcnt == '0) && !byte_vld_o)); // R9

endmodule

// File: rtl/mfm_read_sep.sv
module mfm_read_sep #(
  parameter int NDRV = 4,
  parameter int OSR  = 4,
  parameter int BW   = 8,
  localparam int SELW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDRV-1:0] drv_i,
  input  logic [SELW-1:0] drv_sel_i,
  input  logic            read_gate_i,
  output logic [BW-1:0]   byte_o,
  output logic            byte_vld_o,
  output logic            rclk_o,
  output logic            ref2x_o,
  output logic            wclk_o
);

  logic ref_pulse;
  logic trk_pulse;
  logic cell_end;
  logic dbit;

  mfm_ref_div #(.OSR(OSR)) u_div (
    .clk(clk), .rst(rst),
    .ref_pulse_o(ref_pulse), .ref2x_o(ref2x_o), .wclk_o(wclk_o)
  );

  mfm_in_select #(.NDRV(NDRV), .SELW(SELW), .SYNC_N(2)) u_sel (
    .clk(clk), .rst(rst),
    .drv_i(drv_i), .sel_i(drv_sel_i), .read_gate_i(read_gate_i),
    .ref_pulse_i(ref_pulse), .trk_pulse_o(trk_pulse)
  );

  mfm_phase_track #(.OSR(OSR)) u_trk (
    .clk(clk), .rst(rst), .pulse_i(trk_pulse),
    .cell_end_o(cell_end), .dbit_o(dbit), .rclk_o(rclk_o)
  );

  mfm_byte_asm #(.BW(BW)) u_asm (
    .clk(clk), .rst(rst), .read_gate_i(read_gate_i),
    .cell_end_i(cell_end), .dbit_i(dbit),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o)
  );

endmodule

// File: tb/sim_mfm_read_sep.sv
module sim_mfm_read_sep;
  localparam int CLK_PERIOD = 10;
  localparam int OSR = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] drv_i = '0;
  logic [1:0] drv_sel_i = '0;
  logic       read_gate_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld_o, rclk_o, ref2x_o, wclk_o;

  int checks = 0;
  int errors = 0;
  int lph = 0;
  int cur_sel = 0;
  logic [3:0] nz = 4'b0101;
  bit tracking = 0;
  int rclk_bad = 0;
  int vld_bad = 0;
  logic bits_a [0:63];
  logic [7:0] exp_b [0:7];
  logic [7:0] got [0:15];
  int gotn = 0;

  mfm_read_sep u0 (
    .clk(clk), .rst(rst), .drv_i(drv_i), .drv_sel_i(drv_sel_i),
    .read_gate_i(read_gate_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .rclk_o(rclk_o), .ref2x_o(ref2x_o), .wclk_o(wclk_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // One tick: sample outputs at the falling edge, then drive this tick's inputs.
  task automatic adv(input logic d);
    @(negedge clk);
    lph = (lph + 1) % OSR;
    if (tracking) begin
      if (rclk_o !== (lph >= OSR/2)) rclk_bad++;
      if (byte_vld_o === 1'b1) begin
        if (lph != 0) vld_bad++;
        if (gotn < 16) got[gotn] = byte_o;
        gotn++;
      end
    end
    nz = ~nz;
    drv_i = nz;
    drv_i[cur_sel] = d;
  endtask

  // Find the clock-to-data window boundary; afterwards lph is the design's phase.
  task automatic align();
    logic prev;
    prev = rclk_o;
    for (int i = 0; i < 16; i++) begin
      adv(1'b0);
      if (!prev && rclk_o) break;
      prev = rclk_o;
    end
    lph = OSR/2;
  endtask

  task automatic load(input int nb);
    for (int k = 0; k < nb; k++)
      for (int j = 0; j < 8; j++)
        bits_a[k*8 + j] = exp_b[k][7-j];
  endtask

  // MFM-encode n bits and play them on drive sel, timed so each pulse is judged at its window centre.
  task automatic send_bits(input int sel, input int n);
    cur_sel = sel;
    drv_sel_i = 2'(sel);
    gotn = 0;
    rclk_bad = 0;
    vld_bad = 0;
    tracking = 0;
    for (int i = 0; i < 4; i++) adv(1'b0);
    align();
    tracking = 1;
    adv(n > 0 && !bits_a[0]);
    read_gate_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      adv(1'b0);
      adv(bits_a[i]);
      adv(1'b0);
      adv((i + 1 < n) && !bits_a[i] && !bits_a[i+1]);
    end
    adv(1'b0);
    adv(1'b0);
    read_gate_i = 1'b0;
    tracking = 0;
  endtask

  task automatic check_bytes(input int nb, input string tag);
    chk(gotn == nb, {tag, " byte count"}, gotn, nb);
    for (int k = 0; k < nb && k < gotn; k++)
      chk(got[k] == exp_b[k], tag, got[k], exp_b[k]);
    chk(vld_bad == 0, "R8 strobe not in tick 0 of next cell", vld_bad, 0);
    chk(rclk_bad == 0, "R5 rclk_o not following cell phase", rclk_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(byte_o == 8'h00, "R1 byte_o", byte_o, 0);
    chk(byte_vld_o == 1'b0, "R1 byte_vld_o", byte_vld_o, 0);
    chk(rclk_o == 1'b0, "R1 rclk_o", rclk_o, 0);
    chk({wclk_o, ref2x_o} == 2'b00, "R1 wclk_o/ref2x_o", {wclk_o, ref2x_o}, 0);
    rst = 1'b0;

    // R2: divider outputs, tick k after reset release
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk(ref2x_o == ((k % 2) == 1), "R2 ref2x_o", ref2x_o, (k % 2));
      chk(wclk_o == ((k % OSR) >= OSR/2), "R2 wclk_o", wclk_o, ((k % OSR) >= OSR/2));
    end

    // R4: gate closed, selected line carries stray pulses, phase must stay on the reference
    repeat (20) adv(1'b0);
    align();
    rclk_bad = 0;
    tracking = 1;
    for (int i = 0; i < 48; i++) adv(((i * 7) % 3) == 0);
    tracking = 0;
    chk(rclk_bad == 0, "R4 rclk_o disturbed while gate closed", rclk_bad, 0);
    chk(gotn == 0, "R4 byte emitted while gate closed", gotn, 0);

    // R6 / R10: zeros, ones and a byte that ends on a data pulse
    exp_b[0] = 8'h00; exp_b[1] = 8'hFF; exp_b[2] = 8'h01;
    load(3); send_bits(0, 24);
    check_bytes(3, "R6 R10 decode");

    // R3: sweep every drive index with the other lines toggling
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 3; k++) exp_b[k] = 8'((s * 67 + k * 29 + 1) & 255);
      exp_b[3] = (s % 2 == 0) ? 8'hA5 : 8'h5A;
      load(4); send_bits(s, 32);
      check_bytes(4, "R3 drive select");
    end

    // R8: MSB-first framing on an asymmetric byte
    exp_b[0] = 8'h80; exp_b[1] = 8'h3C;
    load(2); send_bits(1, 16);
    check_bytes(2, "R8 framing");

    // R9: partial byte then a full one
    bits_a[0] = 1; bits_a[1] = 0; bits_a[2] = 1; bits_a[3] = 1; bits_a[4] = 0;
    send_bits(2, 5);
    chk(gotn == 0, "R9 partial byte emitted", gotn, 0);
    exp_b[0] = 8'hC3;
    load(1); send_bits(2, 8);
    check_bytes(1, "R9 fresh byte");

    // R7: one early data pulse pulls the cell boundary in by a tick
    cur_sel = 3; drv_sel_i = 2'd3;
    for (int i = 0; i < 4; i++) adv(1'b0);
    align();
    adv(1'b0);
    read_gate_i = 1'b1;
    adv(1'b1);
    adv(1'b0);
    adv(1'b0);
    chk(rclk_o == 1'b1, "R7 data window before early pulse", rclk_o, 1);
    adv(1'b0);
    chk(rclk_o == 1'b0, "R7 early pulse advanced phase", rclk_o, 0);
    adv(1'b0);
    chk(rclk_o == 1'b0, "R7 phase after advance tick 1", rclk_o, 0);
    adv(1'b0);
    chk(rclk_o == 1'b1, "R7 phase after advance tick 2", rclk_o, 1);
    read_gate_i = 1'b0;
    repeat (4) adv(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule